// File: doc/BRIEF.md
# Three-Instruction Multicycle Sequencer

This block is a small, non-pipelined processor core for a 32-bit load/store instruction set. It recognises three instructions: a register-to-register add, a word load that forms its address from a base register plus a signed 16-bit displacement, and an unconditional jump. Any other encoding is a no-op that only advances the program counter.

Every instruction passes through the same seven steps, one clock cycle each: fetch, decode, operand read, execute, memory access, register write and program-counter update. The next fetch starts only after the register write and the PC update of the previous instruction are done. Instruction fetch and data loads share one word-wide read port with a same-cycle (combinational) read. Debug outputs expose the program counter, every register-file write, and a one-cycle pulse as each instruction completes. The register file has 32 entries, and entry 0 is fixed at zero.

Top module: `toc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the PC reads 0. The read strobe is high with the address at 0, and no register write or retire pulse is shown.
- R2: A word with bits [31:26]=000000 and bits [5:0]=100000 is an add. The core writes reg[bits 25:21] + reg[bits 20:16], modulo 2^32, into reg[bits 15:11]. For example, 0x00471820 writes r2+r7 into r3.
- R3: A word with bits [31:26]=100011 is a load. The core reads the memory word at reg[bits 25:21] + displacement (bits 15:0) and writes it into reg[bits 20:16]. It presents that address on the memory port with the read strobe high. For example, 0x8C0803EC loads address 1004 into r8.
- R4: Before the displacement is added, it is sign-extended from 16 to 32 bits, so 0xFFFC subtracts 4 from the base.
- R5: A word with bits [31:26]=000010 is a jump. It writes no register, and the new PC is {(PC+4)[31:28], bits [25:0], 2'b00}.
- R6: Every instruction other than a jump sets the new PC to PC+4. The PC changes only at the end of the update step.
- R7: Register 0 always reads as zero. An add or load whose destination is register 0 produces no register write.
- R8: Any other opcode, and opcode 000000 with a funct other than 100000, writes no register and advances the PC by 4.
- R9: Each instruction takes exactly 7 cycles. The retire pulse is high in the 7th cycle, with the PC still showing that instruction's address. At most one register write occurs, and it happens before the retire pulse.
- R10: The read strobe is high once per instruction for the fetch, at the PC. A load raises it a second time, at its data address. No other cycle raises the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address on the shared memory port |
| mem_rd | output | 1 | Read strobe on the shared port |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| dbg_pc | output | 32 | Current program counter |
| dbg_retire | output | 1 | High in the final cycle of each instruction |
| dbg_wr_en | output | 1 | A register-file write happens this cycle |
| dbg_wr_idx | output | 5 | Index of the register being written |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The collision that matters here is the one inside a single instruction. In an add such as r4 = r4 + r3, the same register is read as an operand and then overwritten, and the sum must use the old value. Through the shared port, a fetch and a load can also target the same memory word. The bench provokes both cases. Directed code and random code both reuse destination registers as sources, and loads are steered at addresses that alias instruction words. Every write and every load address is judged against a bench model that retires instructions strictly in order.

// File: rtl/toc_pkg.sv
package toc_pkg;

   localparam int INSN_W  = 32;
   localparam int OPC_W   = 6;
   localparam int RIDX_W  = 5;
   localparam int FUNCT_W = 6;
   localparam int IMM_W   = 16;
   localparam int TGT_W   = 26;

   localparam logic [OPC_W-1:0]   OPC_RTYPE = 6'b000000;
   localparam logic [OPC_W-1:0]   OPC_LOADW = 6'b100011;
   localparam logic [OPC_W-1:0]   OPC_JUMP  = 6'b000010;
   localparam logic [FUNCT_W-1:0] FN_ADD    = 6'b100000;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_READ   = 3'd2,
      ST_EXEC   = 3'd3,
      ST_MEM    = 3'd4,
      ST_WRITE  = 3'd5,
      ST_NEXT   = 3'd6
   } step_e;

   typedef enum logic [1:0] {
      OP_NOP  = 2'd0,
      OP_ADD  = 2'd1,
      OP_LOAD = 2'd2,
      OP_JUMP = 2'd3
   } op_kind_e;

   typedef struct packed {
      op_kind_e            kind;
      logic [RIDX_W-1:0]   src_a;
      logic [RIDX_W-1:0]   src_b;
      logic [RIDX_W-1:0]   dest;
      logic [IMM_W-1:0]    disp;
      logic [TGT_W-1:0]    target;
   } insn_fields_t;

endpackage

// File: rtl/toc_decode.sv
module toc_decode
   import toc_pkg::*;
#(
   parameter bit CHECK_SHAMT = 1'b0
) (
   input  logic [INSN_W-1:0] insn,
   output insn_fields_t      fields
);

   localparam int OPC_LSB = INSN_W - OPC_W;
   localparam int RS_LSB  = OPC_LSB - RIDX_W;
   localparam int RT_LSB  = RS_LSB - RIDX_W;
   localparam int RD_LSB  = RT_LSB - RIDX_W;
   localparam int SH_LSB  = RD_LSB - RIDX_W;

   logic [OPC_W-1:0]   opc;
   logic [FUNCT_W-1:0] funct;
   logic [RIDX_W-1:0]  f_rs, f_rt, f_rd, f_sh;
   logic               shamt_ok;
   logic               is_add, is_load, is_jump;

   assign opc   = insn[INSN_W-1 -: OPC_W];
   assign f_rs  = insn[RS_LSB +: RIDX_W];
   assign f_rt  = insn[RT_LSB +: RIDX_W];
   assign f_rd  = insn[RD_LSB +: RIDX_W];
   assign f_sh  = insn[SH_LSB +: RIDX_W];
   assign funct = insn[FUNCT_W-1:0];

   generate
      if (CHECK_SHAMT) begin : g_strict
         assign shamt_ok = (f_sh == '0);
      end else begin : g_loose
         assign shamt_ok = 1'b1;
      end
   endgenerate

   assign is_add  = (opc == OPC_RTYPE) && (funct == FN_ADD) && shamt_ok;
   assign is_load = (opc == OPC_LOADW);
   assign is_jump = (opc == OPC_JUMP);

   always_comb begin
      fields        = '0;
      fields.src_a  = f_rs;
      fields.src_b  = f_rt;
      fields.disp   = insn[IMM_W-1:0];
      fields.target = insn[TGT_W-1:0];
      if (is_add) begin
         fields.kind = OP_ADD;
         fields.dest = f_rd;
      end else if (is_load) begin
         fields.kind = OP_LOAD;
         fields.dest = f_rt;
      end else if (is_jump) begin
         fields.kind = OP_JUMP;
         fields.dest = '0;
      end else begin
         fields.kind = OP_NOP;
         fields.dest = '0;
      end
   end

endmodule

// File: rtl/toc_regfile.sv
module toc_regfile #(
   parameter int DATA_W  = 32,
   parameter int NREGS   = 32,
   parameter bit ZERO_R0 = 1'b1,
   localparam int IDX_W  = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rb_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] regs_q [NREGS];

   generate
      for (genvar g = 0; g < NREGS; g++) begin : g_ent
         if (ZERO_R0 && (g == 0)) begin : g_zero
            always_ff @(posedge clk) begin
               regs_q[g] <= '0;
            end
         end else begin : g_flop
            always_ff @(posedge clk) begin
               if (rst) begin
                  regs_q[g] <= '0;
               end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                  regs_q[g] <= wr_data;
               end
            end
         end
      end
   endgenerate

   assign ra_data = regs_q[ra_idx];
   assign rb_data = regs_q[rb_idx];

   AST_R0_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (wr_idx != '0)); // R7

   AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wr_en); // R9

endmodule

// File: rtl/toc_ctrl.sv
module toc_ctrl
   import toc_pkg::*;
#(
   parameter int               DATA_W   = 32,
   parameter int               IDX_W    = 5,
   parameter logic [DATA_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst,
   output logic [DATA_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [INSN_W-1:0] ir,
   input  insn_fields_t      dec_now,
   output logic [IDX_W-1:0]  ra_idx,
   output logic [IDX_W-1:0]  rb_idx,
   input  logic [DATA_W-1:0] ra_data,
   input  logic [DATA_W-1:0] rb_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] pc,
   output logic              retire
);

   localparam int EXT_W  = DATA_W - IMM_W;
   localparam int PAGE_W = DATA_W - TGT_W - 2;

   step_e             state_q;
   logic [DATA_W-1:0] pc_q, a_q, b_q, alu_q, mdr_q;
   logic [INSN_W-1:0] ir_q;
   insn_fields_t      dec_q;
   logic [DATA_W-1:0] disp_ext, pc_plus4, jump_pc;
   logic              writes_reg;

   assign disp_ext = {{EXT_W{dec_q.disp[IMM_W-1]}}, dec_q.disp};
   assign pc_plus4 = pc_q + DATA_W'(4);
   assign jump_pc  = {pc_plus4[DATA_W-1 -: PAGE_W], dec_q.target, 2'b00};

   assign writes_reg = ((dec_q.kind == OP_ADD) || (dec_q.kind == OP_LOAD))
                       && (dec_q.dest != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_FETCH;
         pc_q    <= RESET_PC;
         ir_q    <= '0;
         dec_q   <= '0;
         a_q     <= '0;
         b_q     <= '0;
         alu_q   <= '0;
         mdr_q   <= '0;
      end else begin
         unique case (state_q)
            ST_FETCH: begin
               ir_q    <= mem_rdata;
               state_q <= ST_DECODE;
            end
            ST_DECODE: begin
               dec_q   <= dec_now;
               state_q <= ST_READ;
            end
            ST_READ: begin
               a_q     <= ra_data;
               b_q     <= rb_data;
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               if (dec_q.kind == OP_ADD) begin
                  alu_q <= a_q + b_q;
               end else if (dec_q.kind == OP_LOAD) begin
                  alu_q <= a_q + disp_ext;
               end
               state_q <= ST_MEM;
            end
            ST_MEM: begin
               if (dec_q.kind == OP_LOAD) begin
                  mdr_q <= mem_rdata;
               end
               state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               state_q <= ST_NEXT;
            end
            ST_NEXT: begin
               pc_q    <= (dec_q.kind == OP_JUMP) ? jump_pc : pc_plus4;
               state_q <= ST_FETCH;
            end
            default: begin
               state_q <= ST_FETCH;
            end
         endcase
      end
   end

   always_comb begin
      mem_rd   = 1'b0;
      mem_addr = pc_q;
      if (state_q == ST_FETCH) begin
         mem_rd = 1'b1;
      end else if ((state_q == ST_MEM) && (dec_q.kind == OP_LOAD)) begin
         mem_rd   = 1'b1;
         mem_addr = alu_q;
      end
   end

   assign ir      = ir_q;
   assign ra_idx  = dec_q.src_a;
   assign rb_idx  = dec_q.src_b;
   assign wr_en   = (state_q == ST_WRITE) && writes_reg;
   assign wr_idx  = dec_q.dest;
   assign wr_data = (dec_q.kind == OP_LOAD) ? mdr_q : alu_q;
   assign pc      = pc_q;
   assign retire  = (state_q == ST_NEXT);

   AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !retire |=> $stable(pc_q)); // R6

   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      pc_q[1:0] == 2'b00); // R5

   AST_RETIRE_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
      retire |=> (mem_rd && (mem_addr == pc_q))); // R9

   AST_LOAD_STROBED: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (dec_q.kind == OP_LOAD)) |-> $past(mem_rd)); // R10

   AST_JUMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (dec_q.kind == OP_JUMP) |-> !wr_en); // R5

endmodule

// File: rtl/toc_core.sv
module toc_core
   import toc_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                NREGS       = 32,
   parameter logic [DATA_W-1:0] RESET_PC    = '0,
   parameter bit                ZERO_R0     = 1'b1,
   parameter bit                CHECK_SHAMT = 1'b0,
   localparam int               IDX_W       = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst,
   output logic [DATA_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] dbg_pc,
   output logic              dbg_retire,
   output logic              dbg_wr_en,
   output logic [IDX_W-1:0]  dbg_wr_idx,
   output logic [DATA_W-1:0] dbg_wr_data
);

   generate
      if (DATA_W != INSN_W) begin : g_bad_width
         $error("toc_core: DATA_W must equal the 32-bit instruction width");
      end
      if (NREGS != (1 << RIDX_W)) begin : g_bad_nregs
         $error("toc_core: NREGS must match the 5-bit register fields");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset_pc
         $error("toc_core: RESET_PC must be word aligned");
      end
   endgenerate

   logic [INSN_W-1:0] ir;
   insn_fields_t      dec_now;
   logic [IDX_W-1:0]  ra_idx, rb_idx, wr_idx;
   logic [DATA_W-1:0] ra_data, rb_data, wr_data;
   logic              wr_en;

   toc_decode #(
      .CHECK_SHAMT (CHECK_SHAMT)
   ) u_decode (
      .insn   (ir),
      .fields (dec_now)
   );

   toc_regfile #(
      .DATA_W  (DATA_W),
      .NREGS   (NREGS),
      .ZERO_R0 (ZERO_R0)
   ) u_regs (
      .clk     (clk),
      .rst     (rst),
      .ra_idx  (ra_idx),
      .ra_data (ra_data),
      .rb_idx  (rb_idx),
      .rb_data (rb_data),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data)
   );

   toc_ctrl #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .RESET_PC (RESET_PC)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_rdata (mem_rdata),
      .ir        (ir),
      .dec_now   (dec_now),
      .ra_idx    (ra_idx),
      .rb_idx    (rb_idx),
      .ra_data   (ra_data),
      .rb_data   (rb_data),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .pc        (dbg_pc),
      .retire    (dbg_retire)
   );

   assign dbg_wr_en   = wr_en;
   assign dbg_wr_idx  = wr_idx;
   assign dbg_wr_data = wr_data;

endmodule

// File: tb/toc_core_tb_top.sv
module toc_core_tb_top;

   localparam int NINSN = 1500;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] mem_addr, mem_rdata, dbg_pc, dbg_wr_data;
   logic        mem_rd, dbg_retire, dbg_wr_en;
   logic [4:0]  dbg_wr_idx;

   logic [31:0] mem  [256];
   logic [31:0] mreg [32];
   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   assign mem_rdata = mem[mem_addr[9:2]];

   toc_core dut_i (
      .clk         (clk),
      .rst         (rst),
      .mem_addr    (mem_addr),
      .mem_rd      (mem_rd),
      .mem_rdata   (mem_rdata),
      .dbg_pc      (dbg_pc),
      .dbg_retire  (dbg_retire),
      .dbg_wr_en   (dbg_wr_en),
      .dbg_wr_idx  (dbg_wr_idx),
      .dbg_wr_data (dbg_wr_data)
   );

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_mem(logic [31:0] a);
      return mem[a[9:2]];
   endfunction

   function automatic logic [31:0] enc_add(int rs, int rt, int rd, int fn);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
   endfunction

   function automatic logic [31:0] enc_lw(int rs, int rt, logic [15:0] imm);
      return {6'b100011, 5'(rs), 5'(rt), imm};
   endfunction

   function automatic logic [31:0] enc_j(int word);
      return {6'b000010, 26'(word)};
   endfunction

   function automatic logic [31:0] gen_insn();
      int sel = int'($urandom % 10);
      if (sel < 4)       return enc_add($urandom % 32, $urandom % 32, $urandom % 32, 32);
      else if (sel < 7)  return enc_lw($urandom % 32, $urandom % 32, 16'($urandom));
      else if (sel == 7) return enc_j(16 + int'($urandom % 112));
      else if (sel == 8) return {6'b111111, 26'($urandom)};
      else               return enc_add($urandom % 32, $urandom % 32, $urandom % 32, 34);
   endfunction

   initial begin
      int wd;
      wd = 0;
      while (wd < 200000) begin
         @(posedge clk);
         wd++;
      end
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual 0x%08h expected 0x%08h", 32'(wd), 32'd0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] mpc, ins, exp_wd, ld_addr, nxt, first_a, last_a, wdat, sx;
      logic [5:0]  op, fn;
      logic [4:0]  rs, rt, rd, dest, widx;
      bit          is_add, is_ld, is_j, has_wr;
      int          ncyc, nstb, nwr;
      string       tag;

      void'($urandom(32'd20240611));
      for (int i = 16; i < 128; i++) mem[i] = gen_insn();
      for (int i = 128; i < 256; i++) mem[i] = $urandom;
      mem[0]  = 32'h8C0803EC;
      mem[1]  = enc_lw(8, 7, 16'h0004);
      mem[2]  = 32'h00471820;
      mem[3]  = enc_lw(8, 10, 16'hFFFC);
      mem[4]  = enc_add(8, 8, 0, 32);
      mem[5]  = enc_add(0, 8, 9, 32);
      mem[6]  = enc_add(8, 8, 11, 34);
      mem[7]  = {6'b111111, 26'h0};
      mem[8]  = enc_add(4, 3, 4, 32);
      mem[9]  = enc_add(4, 3, 4, 32);
      mem[10] = enc_lw(0, 0, 16'h0010);
      mem[11] = enc_j(16);
      for (int i = 12; i < 16; i++) mem[i] = {6'b111111, 26'h0};
      mem[251] = 32'h0000_0404;
      for (int i = 0; i < 32; i++) mreg[i] = '0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
      check(mem_rd == 1'b1, "R1", "strobe in reset", 32'(mem_rd), 32'd1);
      check(mem_addr == 32'd0, "R1", "addr in reset", mem_addr, 32'd0);
      check(!dbg_wr_en && !dbg_retire, "R1", "write/retire in reset",
            32'({dbg_wr_en, dbg_retire}), 32'd0);
      rst = 1'b0;

      mpc = 32'd0;
      for (int n = 0; n < NINSN; n++) begin
         ins = rd_mem(mpc);
         op = ins[31:26]; fn = ins[5:0];
         rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
         sx = {{16{ins[15]}}, ins[15:0]};
         is_add = (op == 6'b000000) && (fn == 6'b100000);
         is_ld  = (op == 6'b100011);
         is_j   = (op == 6'b000010);
         dest   = is_add ? rd : rt;
         ld_addr = mreg[rs] + sx;
         exp_wd  = is_add ? (mreg[rs] + mreg[rt]) : rd_mem(ld_addr);
         has_wr  = (is_add || is_ld) && (dest != 5'd0);
         nxt = is_j ? {mpc[31:28] + 4'd0, ins[25:0], 2'b00} : mpc + 32'd4;
         if (is_j) nxt[31:28] = (mpc + 32'd4) >> 28;
         if (is_add)     tag = (dest == 0) ? "R7" : "R2";
         else if (is_ld) tag = (dest == 0) ? "R7" : (ins[15] ? "R4" : "R3");
         else if (is_j)  tag = "R5";
         else            tag = "R8";

         ncyc = 0; nstb = 0; nwr = 0;
         first_a = '0; last_a = '0; widx = '0; wdat = '0;
         while (1) begin
            ncyc++;
            if (mem_rd) begin
               if (nstb == 0) first_a = mem_addr; else last_a = mem_addr;
               nstb++;
            end
            if (dbg_wr_en) begin
               nwr++; widx = dbg_wr_idx; wdat = dbg_wr_data;
            end
            if (dbg_retire) break;
            @(negedge clk);
         end

         check(ncyc == 7, "R9", "cycles per instruction", 32'(ncyc), 32'd7);
         check(dbg_pc == mpc, "R6", "pc at retire", dbg_pc, mpc);
         check(first_a == mpc, "R10", "fetch address", first_a, mpc);
         check(nstb == (is_ld ? 2 : 1), "R10", "strobe count", 32'(nstb), is_ld ? 32'd2 : 32'd1);
         if (is_ld)
            check(last_a == ld_addr, ins[15] ? "R4" : "R3", "load address", last_a, ld_addr);
         check(nwr == (has_wr ? 1 : 0), tag, "write count", 32'(nwr), has_wr ? 32'd1 : 32'd0);
         if (has_wr && nwr == 1) begin
            check(widx == dest, tag, "write index", 32'(widx), 32'(dest));
            check(wdat == exp_wd, tag, "write data", wdat, exp_wd);
         end

         if (has_wr) mreg[dest] = exp_wd;
         mpc = nxt;
         @(negedge clk);
         check(dbg_pc == mpc, is_j ? "R5" : "R6", "next pc", dbg_pc, mpc);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule